// File: doc/BRIEF.md
# Result Window Selector and Output Limiter

This block sits at the end of a convolution datapath. It takes a 32-bit final result and keeps a 20-bit slice of it. The slice is taken from one of four windows spaced four bits apart. The window comes either from a 2-bit configuration field or from an automatic chooser. The automatic chooser finds the finest window that still holds the value without overflow.

The kept slice then goes through one of four output-conditioning modes:
- plain truncation,
- symmetric saturation,
- saturation that also clamps negative results to zero,
- a bypass that hands the full 32-bit input on untouched.

A signedness flag says whether the incoming result is two's complement or unsigned. In the conditioning modes the result travels through a fixed-length register pipeline. In bypass that pipeline is skipped, so multi-device chains can forward partial sums with less delay. Configuration is expected to stay steady while data is in flight.

Top module: `win_limit_top`

## Requirements
- R1: With `auto_sel` low, `win_code` picks the window. 00 keeps input bits 31:12, 01 keeps bits 27:8, 10 keeps bits 23:4 and 11 keeps bits 19:0.
- R2: With `auto_sel` high, `win_code` is ignored. The block uses the highest code whose window holds the whole value: for signed input, the bits above the window equal the window's top bit; for unsigned input, the bits above the window are zero. Code 00 is the fallback.
- R3: With `gain_mode` 00 (bypass), `out_data` equals `in_data` exactly. It appears one clock after the input is accepted.
- R4: With `gain_mode` 01, the output is the 20-bit window. It is sign-extended to 32 bits when `is_signed` is 1 and zero-extended otherwise, and it wraps on overflow.
- R5: With `gain_mode` 10 and signed data, a value outside the window range is clamped to 0x7FFFF or to -0x80000 (sign-extended).
- R6: For unsigned data in `gain_mode` 10 or 11, a value too large for the window is clamped to 0x000FFFFF.
- R7: With `gain_mode` 11 and signed data, a negative input gives 0. A positive value too large for the window gives 0x0007FFFF.
- R8: In `gain_mode` 01, 10 and 11 the result appears 14 clocks after the input is accepted. That is 13 clocks later than in bypass.
- R9: While `rst` is high, `out_valid` and `out_data` are 0 from the next clock on.
- R10: `out_valid` is high exactly once for each accepted input, and never in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 32 | Final 32-bit result |
| is_signed | input | 1 | 1: two's complement input, 0: unsigned |
| auto_sel | input | 1 | 1: automatic window choice |
| win_code | input | 2 | Manual window code |
| gain_mode | input | 2 | 00 bypass, 01 normal, 10 saturate, 11 clamp negatives and saturate |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Conditioned result |

## Verification
A bypassed word is due one clock after the edge that accepts it; a word in any other mode is due fourteen clocks after that edge. For each accepted word the bench stores the expected value and its due cycle in a queue. At every falling edge it compares the front entry against the outputs in exactly that cycle, and it flags any valid output that has no entry due. Between configurations the stream pauses longer than the deep path. This keeps the two latencies from overlapping when the mode changes, and the input bursts include gaps, so back-to-back and spaced words are both covered.

// File: rtl/wlim_pkg.sv
package wlim_pkg;
  typedef enum logic [1:0] {
    GM_BYPASS  = 2'b00,
    GM_NORMAL  = 2'b01,
    GM_SAT     = 2'b10,
    GM_POSCLIP = 2'b11
  } gain_mode_e;
endpackage

// File: rtl/wlim_window_pick.sv
module wlim_window_pick #(
  parameter int W_IN  = 32,
  parameter int W_OUT = 20,
  parameter int STEP  = 4,
  parameter int NWIN  = 4,
  localparam int CW   = $clog2(NWIN)
) (
  input  logic [W_IN-1:0] din,
  input  logic            is_signed,
  input  logic            auto_sel,
  input  logic [CW-1:0]   code_cfg,
  output logic [CW-1:0]   code_use
);
  logic [NWIN-1:0] fits;

  generate
    for (genvar c = 0; c < NWIN; c++) begin : g_fit
      localparam int TOPLSB = (NWIN-1-c)*STEP + W_OUT - 1;
      logic [W_IN-1:0] hi_s;
      logic [W_IN-1:0] hi_u;
      assign hi_s = $signed(din) >>> TOPLSB;
      assign hi_u = din >> TOPLSB;
      assign fits[c] = is_signed ? ((hi_s == '0) || (hi_s == '1))
                                 : (hi_u[W_IN-1:1] == '0);
    end
  endgenerate

  always_comb begin
    code_use = code_cfg;
    if (auto_sel) begin
      code_use = '0;
      for (int c = 0; c < NWIN; c++)
        if (fits[c]) code_use = CW'(c);
    end
  end

  always_comb begin
    if (auto_sel) begin
      // R2
      auto_fit_chk: assert (fits[code_use]);
      if (int'(code_use) < NWIN-1)
        // R2
        auto_finest_chk: assert (!fits[int'(code_use)+1]);
    end
  end
endmodule

// File: rtl/wlim_clip.sv
module wlim_clip
  import wlim_pkg::*;
#(
  parameter int W_IN  = 32,
  parameter int W_OUT = 20,
  parameter int STEP  = 4,
  parameter int NWIN  = 4,
  localparam int CW   = $clog2(NWIN)
) (
  input  logic [W_IN-1:0] din,
  input  logic            is_signed,
  input  logic [CW-1:0]   code,
  input  gain_mode_e      mode,
  output logic [W_IN-1:0] dout
);
  localparam logic [W_OUT-1:0] SMAX = {1'b0, {(W_OUT-1){1'b1}}};
  localparam logic [W_OUT-1:0] SMIN = {1'b1, {(W_OUT-1){1'b0}}};
  localparam logic [W_OUT-1:0] UMAX = '1;

  int              sh;
  logic [W_IN-1:0] q;
  logic [W_OUT-1:0] win, lim;
  logic            ovf, neg;

  function automatic logic [W_IN-1:0] sx(input logic [W_OUT-1:0] v);
    return {{(W_IN-W_OUT){v[W_OUT-1]}}, v};
  endfunction

  function automatic logic [W_IN-1:0] zx(input logic [W_OUT-1:0] v);
    return {{(W_IN-W_OUT){1'b0}}, v};
  endfunction

  always_comb begin
    sh = (NWIN - 1 - int'(code)) * STEP;
    if (is_signed) q = $signed(din) >>> sh;
    else           q = din >> sh;
    win = q[W_OUT-1:0];
    neg = is_signed & din[W_IN-1];
    if (is_signed)
      ovf = !((q[W_IN-1:W_OUT-1] == '0) || (q[W_IN-1:W_OUT-1] == '1));
    else
      ovf = (q[W_IN-1:W_OUT] != '0);
    if (is_signed) lim = ovf ? (neg ? SMIN : SMAX) : win;
    else           lim = ovf ? UMAX : win;
    case (mode)
      GM_NORMAL:  dout = is_signed ? sx(win) : zx(win);
      GM_SAT:     dout = is_signed ? sx(lim) : zx(lim);
      GM_POSCLIP: dout = neg ? '0 : (is_signed ? sx(lim) : zx(lim));
      default:    dout = din;
    endcase
  end

  always_comb begin
    if (mode == GM_SAT && is_signed)
      // R5
      sat_range_chk: assert ((dout[W_IN-1:W_OUT-1] == '0) || (dout[W_IN-1:W_OUT-1] == '1));
    if (!is_signed && (mode == GM_SAT || mode == GM_POSCLIP))
      // R6
      usat_range_chk: assert (dout[W_IN-1:W_OUT] == '0);
    if (mode == GM_POSCLIP && is_signed)
      // R7
      neg_zero_chk: assert (!dout[W_IN-1] && (!din[W_IN-1] || dout == '0));
  end
endmodule

// File: rtl/wlim_delay_pipe.sv
module wlim_delay_pipe #(
  parameter int W     = 32,
  parameter int DEPTH = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign out_v = in_v;
      assign out_d = in_d;
    end else begin : g_regs
      logic [W-1:0] d_sr [DEPTH];
      logic [DEPTH-1:0] v_sr;
      always_ff @(posedge clk) begin
        d_sr[0] <= in_d;
        for (int i = 1; i < DEPTH; i++) d_sr[i] <= d_sr[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst) v_sr <= '0;
        else if (DEPTH == 1) v_sr <= in_v;
        else v_sr <= {v_sr[DEPTH-2:0], in_v};
      end
      assign out_v = v_sr[DEPTH-1];
      assign out_d = d_sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/win_limit_top.sv
module win_limit_top
  import wlim_pkg::*;
#(
  parameter int W_IN     = 32,
  parameter int W_OUT    = 20,
  parameter int STEP     = 4,
  parameter int NWIN     = 4,
  parameter int GAIN_LAT = 13,
  localparam int CW      = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [W_IN-1:0] in_data,
  input  logic            is_signed,
  input  logic            auto_sel,
  input  logic [CW-1:0]   win_code,
  input  logic [1:0]      gain_mode,
  output logic            out_valid,
  output logic [W_IN-1:0] out_data
);
  gain_mode_e      mode;
  logic [CW-1:0]   code_use;
  logic [W_IN-1:0] cond;
  logic            tail_v;
  logic [W_IN-1:0] tail_d;
  logic            armed;

  assign mode = gain_mode_e'(gain_mode);

  wlim_window_pick #(.W_IN(W_IN), .W_OUT(W_OUT), .STEP(STEP), .NWIN(NWIN)) u_pick (
    .din(in_data), .is_signed(is_signed), .auto_sel(auto_sel),
    .code_cfg(win_code), .code_use(code_use)
  );

  wlim_clip #(.W_IN(W_IN), .W_OUT(W_OUT), .STEP(STEP), .NWIN(NWIN)) u_clip (
    .din(in_data), .is_signed(is_signed), .code(code_use), .mode(mode), .dout(cond)
  );

  wlim_delay_pipe #(.W(W_IN), .DEPTH(GAIN_LAT)) u_pipe (
    .clk(clk), .rst(rst), .in_v(in_valid), .in_d(cond),
    .out_v(tail_v), .out_d(tail_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      armed     <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (mode == GM_BYPASS) begin
        out_valid <= in_valid;
        out_data  <= in_data;
      end else begin
        out_valid <= tail_v;
        out_data  <= tail_d;
      end
    end
  end

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(gain_mode) == 2'b00) |->
      (out_valid == $past(in_valid) && (!out_valid || out_data == $past(in_data))));

  // R9
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));
endmodule

// File: tb/sim_win_limit_top.sv
module sim_win_limit_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        is_signed = 1'b0, auto_sel = 1'b0;
  logic [1:0]  win_code = '0, gain_mode = '0;
  logic        out_valid;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  win_limit_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .is_signed(is_signed), .auto_sel(auto_sel), .win_code(win_code),
    .gain_mode(gain_mode), .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct { int due; logic [31:0] val; string tag; } exp_t;
  exp_t exq[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(logic [31:0] d, bit s, bit a, int code, int m);
    longint v, q, lo_l, hi_l, r;
    int c, lo;
    v = s ? longint'($signed(d)) : longint'({32'd0, d});
    if (m == 0) return d;
    lo_l = s ? -(longint'(1) << 19) : 0;
    hi_l = s ? (longint'(1) << 19) - 1 : (longint'(1) << 20) - 1;
    c = code;
    if (a) begin
      c = 0;
      for (int k = 3; k >= 0; k--) begin
        q = v >>> ((3 - k) * 4);
        if (q >= lo_l && q <= hi_l) begin c = k; break; end
      end
    end
    lo = (3 - c) * 4;
    q = v >>> lo;
    if (m == 1) begin
      r = q & 64'hFFFFF;
      if (s && r >= (longint'(1) << 19)) r = r - (longint'(1) << 20);
    end else begin
      r = (q > hi_l) ? hi_l : (q < lo_l) ? lo_l : q;
      if (m == 3 && s && v < 0) r = 0;
    end
    return r[31:0];
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exq.size() > 0 && exq[0].due == cyc) begin
        chk(out_valid === 1'b1 && out_data === exq[0].val, exq[0].tag, out_data, exq[0].val);
        void'(exq.pop_front());
      end else if (out_valid !== 1'b0) begin
        chk(1'b0, "R10 unexpected valid", out_data, 32'd0);
      end
    end
  end

  task automatic send(logic [31:0] d, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    e.due = cyc + ((gain_mode == 2'b00) ? 1 : 14);
    e.val = model(d, is_signed, auto_sel, int'(win_code), int'(gain_mode));
    e.tag = tag;
    exq.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_BEEF;
    end
  endtask

  logic [31:0] vecs [10] = '{32'h0000_1234, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFF0,
                             32'h0007_FFFF, 32'h0008_0000, 32'hFFF8_0000, 32'hFFF7_FFFF,
                             32'h00AB_CDEF, 32'h0123_4567};

  initial begin
    int seed = 32'h1357_9BDF;
    string tag;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_data === 32'd0, "R9 reset state", out_data, 32'd0);
    rst = 1'b0;
    idle(2);
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 2; a++)
          for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            gain_mode = 2'(m); is_signed = 1'(s); auto_sel = 1'(a); win_code = 2'(c);
            in_valid = 1'b0;
            if (m == 0) tag = "R3 bypass";
            else tag = $sformatf("%s %s R8 R10 m=%0d s=%0d c=%0d",
                                 a ? "R2" : "R1",
                                 m == 1 ? "R4" : (m == 2 ? (s ? "R5" : "R6") : (s ? "R7" : "R6")),
                                 m, s, c);
            for (int v = 0; v < 12; v++) begin
              logic [31:0] d;
              if (v < 10) d = vecs[v];
              else begin seed = seed * 1103515245 + 12345; d = 32'(seed); end
              send(d, tag);
              if (v % 3 == 2) idle(1);
            end
            idle(16);
          end
    chk(exq.size() == 0, "R10 all results delivered", 32'(exq.size()), 32'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule